// File: doc/BRIEF.md
# Region-of-interest decimating scaler

This block sits in a streaming pixel path and shrinks a rectangular window of each incoming frame to a programmed output size. The input frame is 640x480 pixels by default (both dimensions are parameters). Software programs six values:

- the window's starting column and row;
- the window's width and height;
- the number of output pixels per line and output lines per frame.

Any integer output size up to the window size is allowed. Examples are 320x240, 160x120, 352x288 and 176x144 from the full frame. Downscaling the full frame keeps the whole field of view.

A window smaller than the frame gives zoom. The zoom factor is the frame size divided by the window size; for example, a 160x120 window shown at 160x120 is a 4x zoom. Moving the window's start coordinates pans the view. The block keeps pixels and lines with a per-axis fractional step, so non-power-of-two ratios spread the kept samples evenly. Each output frame carries exactly the programmed pixel and line counts.

The input stream carries a valid strobe, a start-of-frame mark on the first pixel and an end-of-line mark on the last pixel of each row. The output stream carries the same marks plus a line-valid and a frame-valid level.

Top module: `roi_scaler`

## Requirements
- R1: After reset every output is 0.
- R2: The window is clamped to the frame. A start column or row beyond the frame becomes the last column or row. A size of 0 becomes 1. A size that runs past the frame edge is cut at the edge.
- R3: An output count of 0 becomes 1. An output count larger than the clamped window size becomes the window size.
- R4: Every output frame holds exactly the clamped output line count. Each of those lines holds exactly the clamped output pixel count.
- R5: Let i be a pixel's index within the window on one axis, n the window size on that axis and o the output count on that axis. The pixel passes that axis iff floor((i+1)*o/n) > floor(i*o/n). A pixel is emitted iff it passes both axes, so the window's last column and last row are always kept.
- R6: An emitted pixel appears on the outputs one clock after it is accepted at the input, with the same data value.
- R7: out_sof is 1 with the first emitted pixel of a frame. out_eol is 1 with the last emitted pixel of each output line, which is the pixel in the window's last column.
- R8: out_line_valid is 1 from the first emitted pixel of an output line through its out_eol pixel, idle cycles included, and 0 between output lines.
- R9: out_frame_valid is 1 from the out_sof pixel through the out_eol pixel of the last output line, and 0 otherwise.
- R10: The six configuration inputs are sampled only on the input start-of-frame pixel. Changes at any other time do not affect the current frame.
- R11: Pixels outside the window, and idle input cycles, produce no output pixel. out_data is 0 whenever out_valid is 0.
- R12: When the output size equals the window size, every window pixel is emitted unchanged. This gives a pure crop, used for zoom and pan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| roi_col | input | XW | Window start column |
| roi_row | input | YW | Window start row |
| roi_width | input | XW | Window width in pixels |
| roi_height | input | YW | Window height in lines |
| dst_width | input | XW | Output pixels per line |
| dst_height | input | YW | Output lines per frame |
| in_valid | input | 1 | Input pixel strobe |
| in_sof | input | 1 | First pixel of the input frame |
| in_eol | input | 1 | Last pixel of an input row |
| in_data | input | DW | Input pixel value |
| out_valid | output | 1 | Output pixel strobe |
| out_sof | output | 1 | First output pixel of the frame |
| out_eol | output | 1 | Last output pixel of a line |
| out_line_valid | output | 1 | Output line in progress |
| out_frame_valid | output | 1 | Output frame in progress |
| out_data | output | DW | Output pixel value |

XW is $clog2(FRAME_W+1) and YW is $clog2(FRAME_H+1).

## Verification
Every output of this block comes from a single register stage. The pixel, its marks and both valid levels for an input accepted at a rising edge are therefore due on the outputs right after that edge. The bench applies each input at a falling edge. At the next falling edge, one rising edge later, it compares all six outputs with the values its reference model derived for that input, before it applies the next input. Per-frame pixel and line totals are compared after one extra idle cycle has flushed the last output pixel.

// File: rtl/roi_scl_pkg.sv
package roi_scl_pkg;

  // Start coordinate, forced inside the frame.
  function automatic int clip_origin(input int req, input int full);
    return (req > full - 1) ? full - 1 : req;
  endfunction

  // Window span: at least one, never past the frame edge.
  function automatic int clip_span(input int req, input int origin, input int full);
    int s;
    s = (req == 0) ? 1 : req;
    if (origin + s > full) s = full - origin;
    return s;
  endfunction

  // Output count: at least one, never above the window span.
  function automatic int clip_count(input int req, input int span);
    if (req == 0) return 1;
    return (req > span) ? span : req;
  endfunction

endpackage

// File: rtl/roi_scl_cfg.sv
module roi_scl_cfg #(
  parameter int FW = 640,
  parameter int FH = 480,
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [XW-1:0] req_x,
  input  logic [XW-1:0] req_w,
  input  logic [XW-1:0] req_ow,
  input  logic [YW-1:0] req_y,
  input  logic [YW-1:0] req_h,
  input  logic [YW-1:0] req_oh,
  output logic [XW-1:0] x0,
  output logic [XW-1:0] w,
  output logic [XW-1:0] ow,
  output logic [YW-1:0] y0,
  output logic [YW-1:0] h,
  output logic [YW-1:0] oh
);
  import roi_scl_pkg::*;

  logic [XW-1:0] fx0, fw, fow, lx0, lw, low;
  logic [YW-1:0] fy0, fh, foh, ly0, lh, loh;

  always_comb begin
    fx0 = XW'(clip_origin(int'(req_x), FW));
    fw  = XW'(clip_span(int'(req_w), int'(fx0), FW));
    fow = XW'(clip_count(int'(req_ow), int'(fw)));
    fy0 = YW'(clip_origin(int'(req_y), FH));
    fh  = YW'(clip_span(int'(req_h), int'(fy0), FH));
    foh = YW'(clip_count(int'(req_oh), int'(fh)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lx0 <= '0; lw <= XW'(FW); low <= XW'(FW);
      ly0 <= '0; lh <= YW'(FH); loh <= YW'(FH);
    end else if (take) begin
      lx0 <= fx0; lw <= fw; low <= fow;
      ly0 <= fy0; lh <= fh; loh <= foh;
    end
  end

  // The start-of-frame pixel already uses the freshly clamped set.
  assign x0 = take ? fx0 : lx0;
  assign w  = take ? fw  : lw;
  assign ow = take ? fow : low;
  assign y0 = take ? fy0 : ly0;
  assign h  = take ? fh  : lh;
  assign oh = take ? foh : loh;

endmodule

// File: rtl/roi_scl_pos.sv
module roi_scl_pos #(
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eol,
  output logic [XW-1:0] cur_col,
  output logic [YW-1:0] cur_row
);
  logic [XW-1:0] col;
  logic [YW-1:0] row;

  assign cur_col = in_sof ? '0 : col;
  assign cur_row = in_sof ? '0 : row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else if (in_valid) begin
      if (in_eol) begin
        col <= '0;
        row <= cur_row + 1'b1;
      end else begin
        col <= cur_col + 1'b1;
        row <= cur_row;
      end
    end
  end

endmodule

// File: rtl/roi_scl_axis.sv
module roi_scl_axis #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          advance,
  input  logic [AW-1:0] num,
  input  logic [AW-1:0] den,
  output logic          keep
);
  logic [AW-1:0] acc, base;
  logic [AW:0]   sum;

  assign base = restart ? '0 : acc;
  assign sum  = {1'b0, base} + {1'b0, num};
  assign keep = (sum >= {1'b0, den});

  always_ff @(posedge clk) begin
    if (!rst_n)       acc <= '0;
    else if (advance) acc <= keep ? AW'(sum - {1'b0, den}) : AW'(sum);
  end

endmodule

// File: rtl/roi_scl_emit.sv
module roi_scl_emit #(
  parameter int XW = 10,
  parameter int YW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          keep,
  input  logic [XW-1:0] ow,
  input  logic [YW-1:0] oh,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic          out_sof,
  output logic          out_eol,
  output logic          out_line_valid,
  output logic          out_frame_valid,
  output logic [DW-1:0] out_data
);
  logic [XW-1:0] ocol, ocol_b;
  logic [YW-1:0] orow, orow_b;
  logic          fopen, fopen_b, lv_hold, lv_b, fv_hold, fv_b;
  logic          first_px, last_col, last_px;

  assign fopen_b  = frame_start ? 1'b0 : fopen;
  assign lv_b     = frame_start ? 1'b0 : lv_hold;
  assign fv_b     = frame_start ? 1'b0 : fv_hold;
  assign ocol_b   = frame_start ? '0 : ocol;
  assign orow_b   = fopen_b ? orow : '0;
  assign first_px = keep && !fopen_b;
  assign last_col = keep && (ocol_b == ow - 1'b1);
  assign last_px  = last_col && (orow_b == oh - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ocol <= '0; orow <= '0;
      fopen <= 1'b0; lv_hold <= 1'b0; fv_hold <= 1'b0;
      out_valid <= 1'b0; out_sof <= 1'b0; out_eol <= 1'b0;
      out_line_valid <= 1'b0; out_frame_valid <= 1'b0; out_data <= '0;
    end else begin
      fopen   <= fopen_b | keep;
      lv_hold <= keep ? !last_col : lv_b;
      fv_hold <= keep ? !last_px  : fv_b;
      ocol    <= keep ? (last_col ? '0 : ocol_b + 1'b1) : ocol_b;
      orow    <= last_col ? orow_b + 1'b1 : orow_b;
      out_valid       <= keep;
      out_sof         <= first_px;
      out_eol         <= last_col;
      out_line_valid  <= keep | lv_b;
      out_frame_valid <= keep | fv_b;
      out_data        <= keep ? in_data : '0;
    end
  end

endmodule

// File: rtl/roi_scaler.sv
module roi_scaler #(
  parameter int FRAME_W = 640,
  parameter int FRAME_H = 480,
  parameter int DW      = 8,
  localparam int XW     = $clog2(FRAME_W + 1),
  localparam int YW     = $clog2(FRAME_H + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] roi_col,
  input  logic [YW-1:0] roi_row,
  input  logic [XW-1:0] roi_width,
  input  logic [YW-1:0] roi_height,
  input  logic [XW-1:0] dst_width,
  input  logic [YW-1:0] dst_height,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eol,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic          out_sof,
  output logic          out_eol,
  output logic          out_line_valid,
  output logic          out_frame_valid,
  output logic [DW-1:0] out_data
);
  logic          frame_start;
  logic [XW-1:0] x0, w, ow, cur_col;
  logic [YW-1:0] y0, h, oh, cur_row;
  logic [XW:0]   x_end;
  logic [YW:0]   y_end;
  logic          in_x, in_y, in_roi, pix_take, last_x;
  logic          h_keep, v_keep, keep;

  assign frame_start = in_valid && in_sof;

  roi_scl_cfg #(.FW(FRAME_W), .FH(FRAME_H), .XW(XW), .YW(YW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .take(frame_start),
    .req_x(roi_col), .req_w(roi_width), .req_ow(dst_width),
    .req_y(roi_row), .req_h(roi_height), .req_oh(dst_height),
    .x0(x0), .w(w), .ow(ow), .y0(y0), .h(h), .oh(oh)
  );

  roi_scl_pos #(.XW(XW), .YW(YW)) u_pos (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eol(in_eol), .cur_col(cur_col), .cur_row(cur_row)
  );

  assign x_end    = {1'b0, x0} + {1'b0, w};
  assign y_end    = {1'b0, y0} + {1'b0, h};
  assign in_x     = ({1'b0, cur_col} >= {1'b0, x0}) && ({1'b0, cur_col} < x_end);
  assign in_y     = ({1'b0, cur_row} >= {1'b0, y0}) && ({1'b0, cur_row} < y_end);
  assign in_roi   = in_x && in_y;
  assign pix_take = in_valid && in_roi;
  assign last_x   = ({1'b0, cur_col} == x_end - 1'b1);

  roi_scl_axis #(.AW(XW)) u_hstep (
    .clk(clk), .rst_n(rst_n), .restart(cur_col == x0), .advance(pix_take),
    .num(ow), .den(w), .keep(h_keep)
  );

  roi_scl_axis #(.AW(YW)) u_vstep (
    .clk(clk), .rst_n(rst_n), .restart(cur_row == y0),
    .advance(pix_take && last_x), .num(oh), .den(h), .keep(v_keep)
  );

  assign keep = pix_take && h_keep && v_keep;

  roi_scl_emit #(.XW(XW), .YW(YW), .DW(DW)) u_emit (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .keep(keep),
    .ow(ow), .oh(oh), .in_data(in_data),
    .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol),
    .out_line_valid(out_line_valid), .out_frame_valid(out_frame_valid),
    .out_data(out_data)
  );

endmodule

// File: rtl/roi_scaler_chk.sv
module roi_scaler_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_roi,
  input logic          out_valid,
  input logic          out_sof,
  input logic          out_eol,
  input logic          out_line_valid,
  input logic          out_frame_valid,
  input logic [DW-1:0] out_data
);

  assert_outside_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_roi) |=> !out_valid);

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0));

  assert_sof_is_pixel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  assert_eol_is_pixel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_eol |-> out_valid);

  assert_pixel_in_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_line_valid && out_frame_valid));

  assert_line_ends_on_eol_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_line_valid) |-> $past(out_eol));

  assert_frame_ends_on_eol_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_frame_valid) |-> $past(out_eol));

  assert_frame_opens_on_sof_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_frame_valid) |-> out_sof);

endmodule

bind roi_scaler roi_scaler_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_roi(in_roi),
  .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol),
  .out_line_valid(out_line_valid), .out_frame_valid(out_frame_valid),
  .out_data(out_data)
);

// File: tb/roi_scaler_tb.sv
module roi_scaler_tb;
  localparam int FW = 64;
  localparam int FH = 48;
  localparam int DW = 8;
  localparam int XW = $clog2(FW + 1);
  localparam int YW = $clog2(FH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [XW-1:0] cx = '0, cw = '0, cow = '0;
  logic [YW-1:0] cy = '0, ch = '0, coh = '0;
  logic          out_valid, out_sof, out_eol, out_line_valid, out_frame_valid;
  logic [DW-1:0] out_data;

  roi_scaler #(.FRAME_W(FW), .FRAME_H(FH), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .roi_col(cx), .roi_row(cy), .roi_width(cw), .roi_height(ch),
    .dst_width(cow), .dst_height(coh),
    .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol), .in_data(in_data),
    .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol),
    .out_line_valid(out_line_valid), .out_frame_valid(out_frame_valid),
    .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;

  // Expected outputs after the most recently applied input cycle.
  bit            e_valid = 0, e_sof = 0, e_eol = 0, e_lv = 0, e_fv = 0;
  logic [DW-1:0] e_data = '0;
  string         e_tag = "R1";
  bit            lv_h = 0, fv_h = 0;
  int            n_out = 0, n_eol = 0;

  task automatic chk1(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_now();
    chk1(e_tag, "valid R5",      int'(out_valid),       int'(e_valid));
    chk1(e_tag, "data R6/R11",   int'(out_data),        int'(e_data));
    chk1(e_tag, "sof R7",        int'(out_sof),         int'(e_sof));
    chk1(e_tag, "eol R7",        int'(out_eol),         int'(e_eol));
    chk1(e_tag, "line_valid R8", int'(out_line_valid),  int'(e_lv));
    chk1(e_tag, "frame_valid R9", int'(out_frame_valid), int'(e_fv));
    if (out_valid === 1'b1) n_out++;
    if (out_valid === 1'b1 && out_eol === 1'b1) n_eol++;
  endtask

  task automatic step(input bit v, input bit s, input bit e, input logic [DW-1:0] d,
                      input bit k, input bit ks, input bit ke, input bit kl);
    @(negedge clk);
    compare_now();
    in_valid = v; in_sof = s; in_eol = e; in_data = d;
    if (v && s) begin lv_h = 0; fv_h = 0; end
    e_valid = k; e_sof = ks; e_eol = ke;
    e_data  = k ? d : '0;
    e_lv    = k | lv_h;
    e_fv    = k | fv_h;
    if (k) begin lv_h = !ke; fv_h = !kl; end
  endtask

  task automatic run_frame(input string tag, input int rx, input int ry, input int rw,
                           input int rh, input int ow, input int oh, input int gap,
                           input bit disturb, input int seed);
    int x0, y0, w, h, kw, kh;
    bit started;
    x0 = (rx > FW - 1) ? FW - 1 : rx;
    y0 = (ry > FH - 1) ? FH - 1 : ry;
    w  = (rw == 0) ? 1 : rw;
    if (x0 + w > FW) w = FW - x0;
    h  = (rh == 0) ? 1 : rh;
    if (y0 + h > FH) h = FH - y0;
    kw = (ow == 0) ? 1 : ((ow > w) ? w : ow);
    kh = (oh == 0) ? 1 : ((oh > h) ? h : oh);
    cx = XW'(rx); cy = YW'(ry); cw = XW'(rw); ch = YW'(rh); cow = XW'(ow); coh = YW'(oh);
    e_tag = tag;
    started = 0;
    for (int r = 0; r < FH; r++) begin
      int j;
      bit rk;
      j  = r - y0;
      rk = (j >= 0) && (j < h) && (((j + 1) * kh) / h > (j * kh) / h);
      for (int c = 0; c < FW; c++) begin
        int i;
        bit k, ks, ke, kl;
        i  = c - x0;
        k  = rk && (i >= 0) && (i < w) && (((i + 1) * kw) / w > (i * kw) / w);
        ks = k && !started;
        if (k) started = 1;
        ke = k && (i == w - 1);
        kl = ke && (j == h - 1);
        step(1'b1, (r == 0) && (c == 0), c == FW - 1, DW'(r * 7 + c * 3 + seed),
             k, ks, ke, kl);
        if (disturb && r == 0 && c == 1) begin
          // R10: new values after the frame has started must be ignored
          cx = XW'(1); cy = YW'(1); cw = XW'(5); ch = YW'(5); cow = XW'(2); coh = YW'(2);
        end
      end
      for (int g = 0; g < gap; g++) step(1'b0, 1'b0, 1'b0, '0, 0, 0, 0, 0);
    end
    step(1'b0, 1'b0, 1'b0, '0, 0, 0, 0, 0);
    chk1(tag, "pixel count R4", n_out, kw * kh);
    chk1(tag, "line count R4", n_eol, kh);
    n_out = 0;
    n_eol = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R4 actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk1("R1", "reset valid", int'(out_valid), 0);
    chk1("R1", "reset sof", int'(out_sof), 0);
    chk1("R1", "reset eol", int'(out_eol), 0);
    chk1("R1", "reset line_valid", int'(out_line_valid), 0);
    chk1("R1", "reset frame_valid", int'(out_frame_valid), 0);
    chk1("R1", "reset data", int'(out_data), 0);

    run_frame("R4 full frame halved",   0,  0, 64, 48, 32, 24, 1, 0, 0);
    run_frame("R5 odd ratio",          10,  6, 20, 15,  7,  5, 0, 0, 11);
    run_frame("R12 crop zoom and pan", 20, 12, 16, 12, 16, 12, 2, 0, 23);
    run_frame("R2 edge clamp",         60, 45, 20, 20, 10, 10, 1, 0, 5);
    run_frame("R2 zero window size",    7,  9,  0,  0,  3,  3, 0, 0, 9);
    run_frame("R3 count clamp",         3,  2, 30, 20,  0, 25, 0, 0, 31);
    run_frame("R10 mid-frame change",   8,  4, 40, 30, 13, 11, 1, 1, 47);
    run_frame("R11 single-pixel corner", 63, 47, 9, 9,  1,  1, 0, 0, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule